// File: doc/BRIEF.md
# Breakpoint and Trace Event Unit

This unit watches the instructions a processor core retires. For each one it receives the instruction address, a retire-valid strobe and class flags. The flags mark a branch, a call, a return, or one of two software break instructions. When the retiring instruction matches a hardware breakpoint, is a software break, or belongs to an enabled trace class, the unit raises a one-cycle debug event. The event carries a cause bit vector, a priority-resolved event kind, and the address of the instruction.

Every event is post-execution: the instruction that caused it has already retired when the event appears. The unit then drives a stall to the core until the debug handler signals completion, after which retirement continues at the next instruction. The unit has a process-controls word with a global trace enable, a trace-controls word with one enable per trace class, and two breakpoint registers, each with an enable bit. All four are loaded through a simple write port. Retirements that arrive while the unit is halted are ignored, so the handler cannot retrigger itself.

Top module: `dbg_event_unit`

## Requirements
- R1: After a synchronous active-low reset, `ret_stall` and `evt_valid` are 0, `evt_cause` is 0 and `evt_kind` is 0 (none). All breakpoints and all trace enables are off.
- R2: The write port selects registers with `cfg_sel`: 0 is process controls, 1 is trace controls, 2 is breakpoint 0, and 3 is breakpoint 1. A breakpoint word holds the address in bits 31:2 and its enable in bit 0. A retired instruction whose address matches an enabled breakpoint sets cause bit 0 (breakpoint 0) or bit 1 (breakpoint 1), and `evt_ip` reports its address.
- R3: The breakpoint comparison ignores address bits 1:0. A breakpoint whose enable bit is 0 never fires.
- R4: The forced software break (`ret_is_swbrk_force`) always sets cause bit 2. The conditional software break (`ret_is_swbrk_cond`) sets cause bit 3 only when the global trace enable (process-controls bit 0) is 1.
- R5: When the global trace enable is 1, the trace classes each fire under their own trace-controls enable. Single step (bit 1) sets cause bit 4 on every retirement. Branch (bit 2) sets cause bit 5. Call (bit 3) sets cause bit 6. Return (bit 4) sets cause bit 7. When the global trace enable is 0, no trace class fires.
- R6: Every cause that applies to one retired instruction is reported together in `evt_cause`. `evt_kind` names the highest-priority class present: breakpoint is 3, software break is 2, trace is 1, none is 0.
- R7: An event appears as `evt_valid` high for exactly one cycle, in the cycle after the retirement. `ret_stall` rises in that same cycle.
- R8: While `ret_stall` is high, retirements are ignored: no new event is raised and `evt_cause`, `evt_kind` and `evt_ip` hold.
- R9: `handler_done` sampled high while halted drops `ret_stall` and clears `evt_cause` and `evt_kind` on the next cycle. `handler_done` has no effect when the unit is not halted.
- R10: No event is raised in a cycle where `ret_valid` is low, whatever the address and flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_ip | input | 32 | Address of the retiring instruction |
| ret_is_branch | input | 1 | Retiring instruction is a branch |
| ret_is_call | input | 1 | Retiring instruction is a call |
| ret_is_return | input | 1 | Retiring instruction is a return |
| ret_is_swbrk_cond | input | 1 | Software break that fires only when tracing is enabled |
| ret_is_swbrk_force | input | 1 | Software break that always fires |
| handler_done | input | 1 | Debug handler has finished |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | 2 | Register select for the write |
| cfg_wdata | input | 32 | Write data |
| ret_stall | output | 1 | Holds further retirement while halted |
| evt_valid | output | 1 | One-cycle debug event pulse |
| evt_cause | output | 8 | All causes of the current event |
| evt_kind | output | 2 | Highest-priority cause class |
| evt_ip | output | 32 | Address of the instruction that raised the event |

## Verification
A breakpoint hit and trace causes can fall on the same retirement, and so can a conditional software break and a branch trace. The bench provokes this by retiring a branch-and-call instruction at a breakpoint address, and a conditional break that is also a branch. It then judges that every bit appears in one cause word and that the event kind picks the breakpoint, or the software break, over trace. A second overlap is a retirement that arrives while the handler is still running. The bench drives matching retirements during a halt and checks that no pulse appears and that the held cause word does not change.

// File: rtl/dbg_evt_pkg.sv
// Package: shared encodings for the breakpoint and trace event unit.
// Assumes: the cause vector puts the breakpoints at the bottom, followed by the software and trace causes.
package dbg_evt_pkg;
    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_TRACE = 2'd1,
        KIND_SWBRK = 2'd2,
        KIND_BRKPT = 2'd3
    } evt_kind_e;

    localparam int CTRL_W          = 32;
    localparam int PC_TRACE_EN_BIT = 0;
    localparam int TC_STEP_BIT     = 1;
    localparam int TC_BRANCH_BIT   = 2;
    localparam int TC_CALL_BIT     = 3;
    localparam int TC_RETURN_BIT   = 4;
    localparam int BP_ENABLE_BIT   = 0;
    localparam int NONBP_CAUSES    = 6;
endpackage

// File: rtl/dbg_cfg_regs.sv
// Module: control register file. It holds the global trace enable, the per-class
// trace enables and the breakpoint address and enable registers.
// Assumes: a write lands on the next clock edge. Select 0 is process controls,
// select 1 is trace controls, and select 2+i is breakpoint i.
module dbg_cfg_regs
    import dbg_evt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NUM_BP = 2,
    parameter int SEL_W  = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [SEL_W-1:0]                 cfg_sel,
    input  logic [CTRL_W-1:0]                cfg_wdata,
    output logic                             trace_glb_en,
    output logic                             tr_step_en,
    output logic                             tr_branch_en,
    output logic                             tr_call_en,
    output logic                             tr_return_en,
    output logic [NUM_BP-1:0][ADDR_W-3:0]    bp_addr,
    output logic [NUM_BP-1:0]                bp_en
);
    logic [4:0] trace_ctl_q;

    // Purpose: capture the global trace enable from the process-controls word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trace_glb_en <= 1'b0;
        end else if (cfg_we && cfg_sel == SEL_W'(0)) begin
            trace_glb_en <= cfg_wdata[PC_TRACE_EN_BIT];
        end
    end

    // Purpose: capture the per-class trace enables from the trace-controls word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trace_ctl_q <= '0;
        end else if (cfg_we && cfg_sel == SEL_W'(1)) begin
            trace_ctl_q <= cfg_wdata[4:0];
        end
    end

    assign tr_step_en   = trace_ctl_q[TC_STEP_BIT];
    assign tr_branch_en = trace_ctl_q[TC_BRANCH_BIT];
    assign tr_call_en   = trace_ctl_q[TC_CALL_BIT];
    assign tr_return_en = trace_ctl_q[TC_RETURN_BIT];

    for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
        logic [ADDR_W-3:0] addr_q;
        logic              en_q;

        // Purpose: load one breakpoint register: the word address and its enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q <= '0;
                en_q   <= 1'b0;
            end else if (cfg_we && cfg_sel == SEL_W'(i + 2)) begin
                addr_q <= cfg_wdata[ADDR_W-1:2];
                en_q   <= cfg_wdata[BP_ENABLE_BIT];
            end
        end

        assign bp_addr[i] = addr_q;
        assign bp_en[i]   = en_q;
    end
endmodule

// File: rtl/dbg_bp_match.sv
// Module: breakpoint comparators, one per breakpoint register.
// Assumes: instructions are word aligned, so address bits 1:0 take no part in the compare.
module dbg_bp_match #(
    parameter int ADDR_W = 32,
    parameter int NUM_BP = 2
) (
    input  logic [ADDR_W-1:0]              ip,
    input  logic [NUM_BP-1:0][ADDR_W-3:0]  bp_addr,
    input  logic [NUM_BP-1:0]              bp_en,
    output logic [NUM_BP-1:0]              bp_hit
);
    for (genvar i = 0; i < NUM_BP; i++) begin : g_cmp
        // Purpose: flag a match on the word address of one enabled breakpoint.
        always_comb begin
            bp_hit[i] = bp_en[i] && (ip[ADDR_W-1:2] == bp_addr[i]);
        end
    end
endmodule

// File: rtl/dbg_cause_gen.sv
// Module: builds the cause vector for the retiring instruction and resolves the
// event kind by priority (breakpoint, then software break, then trace).
// Assumes: all inputs belong to the same retirement cycle. The module is purely combinational.
module dbg_cause_gen
    import dbg_evt_pkg::*;
#(
    parameter int NUM_BP  = 2,
    parameter int CAUSE_W = NUM_BP + NONBP_CAUSES
) (
    input  logic                ret_valid,
    input  logic                is_branch,
    input  logic                is_call,
    input  logic                is_return,
    input  logic                is_swbrk_cond,
    input  logic                is_swbrk_force,
    input  logic [NUM_BP-1:0]   bp_hit,
    input  logic                trace_glb_en,
    input  logic                tr_step_en,
    input  logic                tr_branch_en,
    input  logic                tr_call_en,
    input  logic                tr_return_en,
    output logic [CAUSE_W-1:0]  cause,
    output evt_kind_e           kind
);
    logic [NUM_BP-1:0] bp_c;
    logic sw_force_c, sw_cond_c, step_c, branch_c, call_c, return_c;

    // Purpose: qualify each cause with retire-valid and its enables.
    always_comb begin
        bp_c       = bp_hit & {NUM_BP{ret_valid}};
        sw_force_c = ret_valid && is_swbrk_force;
        sw_cond_c  = ret_valid && is_swbrk_cond && trace_glb_en;
        step_c     = ret_valid && trace_glb_en && tr_step_en;
        branch_c   = ret_valid && trace_glb_en && tr_branch_en && is_branch;
        call_c     = ret_valid && trace_glb_en && tr_call_en && is_call;
        return_c   = ret_valid && trace_glb_en && tr_return_en && is_return;
    end

    // Purpose: pack the causes into a vector and pick the highest-priority kind.
    always_comb begin
        cause = {return_c, call_c, branch_c, step_c, sw_cond_c, sw_force_c, bp_c};
        if (|bp_c) begin
            kind = KIND_BRKPT;
        end else if (sw_force_c || sw_cond_c) begin
            kind = KIND_SWBRK;
        end else if (step_c || branch_c || call_c || return_c) begin
            kind = KIND_TRACE;
        end else begin
            kind = KIND_NONE;
        end
    end
endmodule

// File: rtl/dbg_halt_ctrl.sv
// Module: halt/resume sequencer. It registers an event, pulses it once, stalls
// retirement and holds the cause until the handler reports completion.
// Assumes: the core retires nothing while the stall is high. Retirements seen anyway are dropped.
module dbg_halt_ctrl
    import dbg_evt_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CAUSE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CAUSE_W-1:0]  cause_in,
    input  evt_kind_e           kind_in,
    input  logic [ADDR_W-1:0]   ip_in,
    input  logic                handler_done,
    output logic                halted,
    output logic                evt_pulse,
    output logic [CAUSE_W-1:0]  cause_q,
    output evt_kind_e           kind_q,
    output logic [ADDR_W-1:0]   ip_q
);
    typedef enum logic {ST_RUN = 1'b0, ST_HALT = 1'b1} halt_st_e;
    halt_st_e state;

    // Purpose: step the run/halt state and capture or clear the event record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_RUN;
            evt_pulse <= 1'b0;
            cause_q   <= '0;
            kind_q    <= KIND_NONE;
            ip_q      <= '0;
        end else begin
            evt_pulse <= 1'b0;
            case (state)
                ST_RUN: begin
                    if (|cause_in) begin
                        state     <= ST_HALT;
                        evt_pulse <= 1'b1;
                        cause_q   <= cause_in;
                        kind_q    <= kind_in;
                        ip_q      <= ip_in;
                    end
                end
                default: begin
                    if (handler_done) begin
                        state   <= ST_RUN;
                        cause_q <= '0;
                        kind_q  <= KIND_NONE;
                    end
                end
            endcase
        end
    end

    assign halted = (state == ST_HALT);
endmodule

// File: rtl/dbg_event_unit.sv
// Module: top of the breakpoint and trace event unit. It ties the control registers,
// the breakpoint comparators, the cause builder and the halt sequencer together.
// Assumes: one retirement per cycle at most. The write port is usable in any state.
module dbg_event_unit
    import dbg_evt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NUM_BP = 2,
    parameter int SEL_W  = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              ret_valid,
    input  logic [ADDR_W-1:0]                 ret_ip,
    input  logic                              ret_is_branch,
    input  logic                              ret_is_call,
    input  logic                              ret_is_return,
    input  logic                              ret_is_swbrk_cond,
    input  logic                              ret_is_swbrk_force,
    input  logic                              handler_done,
    input  logic                              cfg_we,
    input  logic [SEL_W-1:0]                  cfg_sel,
    input  logic [31:0]                       cfg_wdata,
    output logic                              ret_stall,
    output logic                              evt_valid,
    output logic [NUM_BP+NONBP_CAUSES-1:0]    evt_cause,
    output logic [1:0]                        evt_kind,
    output logic [ADDR_W-1:0]                 evt_ip
);
    localparam int CAUSE_W = NUM_BP + NONBP_CAUSES;

    logic                           trace_glb_en, tr_step_en, tr_branch_en, tr_call_en, tr_return_en;
    logic [NUM_BP-1:0][ADDR_W-3:0]  bp_addr;
    logic [NUM_BP-1:0]              bp_en;
    logic [NUM_BP-1:0]              bp_hit;
    logic [CAUSE_W-1:0]             cause_now;
    evt_kind_e                      kind_now;
    evt_kind_e                      kind_held;

    dbg_cfg_regs #(.ADDR_W(ADDR_W), .NUM_BP(NUM_BP), .SEL_W(SEL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .trace_glb_en(trace_glb_en), .tr_step_en(tr_step_en), .tr_branch_en(tr_branch_en),
        .tr_call_en(tr_call_en), .tr_return_en(tr_return_en), .bp_addr(bp_addr), .bp_en(bp_en)
    );

    dbg_bp_match #(.ADDR_W(ADDR_W), .NUM_BP(NUM_BP)) u_match (
        .ip(ret_ip), .bp_addr(bp_addr), .bp_en(bp_en), .bp_hit(bp_hit)
    );

    dbg_cause_gen #(.NUM_BP(NUM_BP), .CAUSE_W(CAUSE_W)) u_cause (
        .ret_valid(ret_valid), .is_branch(ret_is_branch), .is_call(ret_is_call),
        .is_return(ret_is_return), .is_swbrk_cond(ret_is_swbrk_cond),
        .is_swbrk_force(ret_is_swbrk_force), .bp_hit(bp_hit), .trace_glb_en(trace_glb_en),
        .tr_step_en(tr_step_en), .tr_branch_en(tr_branch_en), .tr_call_en(tr_call_en),
        .tr_return_en(tr_return_en), .cause(cause_now), .kind(kind_now)
    );

    dbg_halt_ctrl #(.ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W)) u_halt (
        .clk(clk), .rst_n(rst_n), .cause_in(cause_now), .kind_in(kind_now), .ip_in(ret_ip),
        .handler_done(handler_done), .halted(ret_stall), .evt_pulse(evt_valid),
        .cause_q(evt_cause), .kind_q(kind_held), .ip_q(evt_ip)
    );

    assign evt_kind = kind_held;
endmodule

// File: rtl/dbg_event_unit_chk.sv
// Module: assertion checker for the event unit, attached to the top module by bind.
// Assumes: default parameters, so the two breakpoint causes sit in evt_cause[1:0].
module dbg_event_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ret_valid,
    input logic        handler_done,
    input logic        ret_stall,
    input logic        evt_valid,
    input logic [7:0]  evt_cause,
    input logic [1:0]  evt_kind,
    input logic [31:0] evt_ip
);
    // R6: a breakpoint cause always outranks the other classes
    assert_bp_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_cause[1:0] != 2'b00) |-> evt_kind == 2'd3);
    // R7: the event is a single-cycle pulse
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> !evt_valid);
    // R7: the stall is up whenever an event is signalled
    assert_stall_with_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> ret_stall);
    // R8: while halted without completion, the record holds
    assert_hold_while_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_stall && !handler_done) |=> (ret_stall && $stable(evt_cause) && $stable(evt_ip) && !evt_valid));
    // R9: completion releases the stall and clears the cause
    assert_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_stall && handler_done) |=> (!ret_stall && evt_cause == 8'd0 && evt_kind == 2'd0));
    // R10: no retirement, no event
    assert_no_retire_no_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_valid |=> !evt_valid);
endmodule

bind dbg_event_unit dbg_event_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .handler_done(handler_done),
    .ret_stall(ret_stall), .evt_valid(evt_valid), .evt_cause(evt_cause),
    .evt_kind(evt_kind), .evt_ip(evt_ip)
);

// File: tb/dbg_event_unit_test.sv
module dbg_event_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ret_valid = 1'b0;
    logic [31:0] ret_ip = '0;
    logic        ret_is_branch = 1'b0, ret_is_call = 1'b0, ret_is_return = 1'b0;
    logic        ret_is_swbrk_cond = 1'b0, ret_is_swbrk_force = 1'b0;
    logic        handler_done = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        ret_stall, evt_valid;
    logic [7:0]  evt_cause;
    logic [1:0]  evt_kind;
    logic [31:0] evt_ip;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    dbg_event_unit uut (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_ip(ret_ip),
        .ret_is_branch(ret_is_branch), .ret_is_call(ret_is_call), .ret_is_return(ret_is_return),
        .ret_is_swbrk_cond(ret_is_swbrk_cond), .ret_is_swbrk_force(ret_is_swbrk_force),
        .handler_done(handler_done), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ret_stall(ret_stall), .evt_valid(evt_valid), .evt_cause(evt_cause),
        .evt_kind(evt_kind), .evt_ip(evt_ip)
    );

    // flags order: {valid, branch, call, return, swbrk_cond, swbrk_force}
    typedef struct packed {
        logic [31:0] ip;
        logic [5:0]  flags;
        logic [7:0]  cause;
        logic [1:0]  kind;
    } vec_t;

    // setup: bp0=0x1000 enabled, bp1=0x2004 enabled, global trace on, branch+call traced
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0500, 6'b100000, 8'h00, 2'd0},  // R2 plain, no hit
        '{32'h0000_1000, 6'b100000, 8'h01, 2'd3},  // R2 bp0
        '{32'h0000_1003, 6'b100000, 8'h01, 2'd3},  // R3 low bits ignored
        '{32'h0000_2006, 6'b100000, 8'h02, 2'd3},  // R2 bp1
        '{32'h0000_0600, 6'b110000, 8'h20, 2'd1},  // R5 branch trace
        '{32'h0000_0600, 6'b100100, 8'h00, 2'd0},  // R5 return not enabled
        '{32'h0000_0600, 6'b101000, 8'h40, 2'd1},  // R5 call trace
        '{32'h0000_0700, 6'b100010, 8'h08, 2'd2},  // R4 cond break, trace on
        '{32'h0000_0700, 6'b100001, 8'h04, 2'd2},  // R4 forced break
        '{32'h0000_1000, 6'b111000, 8'h61, 2'd3},  // R6 bp + branch + call
        '{32'h0000_0700, 6'b110010, 8'h28, 2'd2},  // R6 cond break + branch
        '{32'h0000_1000, 6'b011001, 8'h00, 2'd0},  // R10 not valid
        '{32'h0000_1004, 6'b100000, 8'h00, 2'd0}   // R3 next word no hit
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // drives one retirement at a negedge; returns at the next negedge with outputs settled
    task automatic retire(input logic [31:0] ip, input logic [5:0] fl);
        ret_ip = ip;
        {ret_valid, ret_is_branch, ret_is_call, ret_is_return, ret_is_swbrk_cond, ret_is_swbrk_force} = fl;
        @(negedge clk);
        {ret_valid, ret_is_branch, ret_is_call, ret_is_return, ret_is_swbrk_cond, ret_is_swbrk_force} = '0;
    endtask

    task automatic resume(input string req);
        handler_done = 1'b1;
        @(negedge clk);
        handler_done = 1'b0;
        chk(req, "stall after done", 32'(ret_stall), 32'd0);
        chk(req, "cause after done", 32'(evt_cause), 32'd0);
        chk(req, "kind after done", 32'(evt_kind), 32'd0);
    endtask

    task automatic report();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "stall", 32'(ret_stall), 32'd0);
        chk("R1", "evt_valid", 32'(evt_valid), 32'd0);
        chk("R1", "cause", 32'(evt_cause), 32'd0);
        chk("R1", "kind", 32'(evt_kind), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 nothing enabled after reset: only forced break fires
        retire(32'h0, 6'b111111);
        chk("R1", "reset-default cause", 32'(evt_cause), 32'h04);
        resume("R9");

        cfg_write(2'd2, 32'h0000_1001);
        cfg_write(2'd3, 32'h0000_2005);
        cfg_write(2'd0, 32'h0000_0001);
        cfg_write(2'd1, 32'h0000_000C);

        for (int i = 0; i < NV; i++) begin
            retire(VECS[i].ip, VECS[i].flags);
            if (VECS[i].cause != 8'h00) begin
                chk("R7", $sformatf("vec%0d pulse", i), 32'(evt_valid), 32'd1);
                chk("R7", $sformatf("vec%0d stall", i), 32'(ret_stall), 32'd1);
                chk("R6", $sformatf("vec%0d cause", i), 32'(evt_cause), 32'(VECS[i].cause));
                chk("R6", $sformatf("vec%0d kind", i), 32'(evt_kind), 32'(VECS[i].kind));
                chk("R2", $sformatf("vec%0d ip", i), evt_ip, VECS[i].ip);
                @(negedge clk);
                chk("R7", $sformatf("vec%0d pulse drop", i), 32'(evt_valid), 32'd0);
                resume("R9");
            end else begin
                chk("R10", $sformatf("vec%0d no event", i), 32'(evt_valid), 32'd0);
                chk("R10", $sformatf("vec%0d no stall", i), 32'(ret_stall), 32'd0);
            end
        end

        // R4 / R5: global trace off silences cond break and trace classes
        cfg_write(2'd0, 32'h0);
        retire(32'h700, 6'b111110);
        chk("R4", "cond break with trace off", 32'(evt_valid), 32'd0);
        retire(32'h700, 6'b100001);
        chk("R4", "forced break with trace off", 32'(evt_cause), 32'h04);
        resume("R9");

        // R5 single step fires on a plain retirement
        cfg_write(2'd0, 32'h1);
        cfg_write(2'd1, 32'h2);
        retire(32'h800, 6'b100000);
        chk("R5", "step cause", 32'(evt_cause), 32'h10);
        chk("R5", "step kind", 32'(evt_kind), 32'd1);
        resume("R9");
        cfg_write(2'd1, 32'h10);
        retire(32'h800, 6'b100100);
        chk("R5", "return cause", 32'(evt_cause), 32'h80);
        resume("R9");
        cfg_write(2'd1, 32'h0);

        // R3 disabled breakpoint does not fire
        cfg_write(2'd2, 32'h0000_1000);
        retire(32'h1000, 6'b100000);
        chk("R3", "disabled bp", 32'(evt_valid), 32'd0);

        // R8 retirements during a halt are ignored
        retire(32'h900, 6'b100001);
        chk("R8", "setup event", 32'(evt_cause), 32'h04);
        ret_ip = 32'h2004; ret_valid = 1'b1; ret_is_swbrk_force = 1'b1; ret_is_swbrk_cond = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8", "no pulse while halted", 32'(evt_valid), 32'd0);
            chk("R8", "cause held", 32'(evt_cause), 32'h04);
            chk("R8", "ip held", evt_ip, 32'h900);
        end
        ret_valid = 1'b0; ret_is_swbrk_force = 1'b0; ret_is_swbrk_cond = 1'b0;
        resume("R9");
        @(negedge clk);
        chk("R8", "no late event", 32'(evt_valid), 32'd0);

        // R9 done while running has no effect; a later event still works
        handler_done = 1'b1;
        @(negedge clk);
        handler_done = 1'b0;
        chk("R9", "idle done stall", 32'(ret_stall), 32'd0);
        retire(32'h2004, 6'b100000);
        chk("R9", "event after idle done", 32'(evt_cause), 32'h02);
        resume("R9");

        report();
    end
endmodule